// File: doc/BRIEF.md
# Frequency Synthesizer Divider Configuration Register

This block holds the divider settings of a frequency synthesizer: a 9-bit main divider value, a 4-bit swallow divider value and an active-low prescaler control. There are two sources for these settings. One is a three-wire serial interface made of a bit clock, a data line and a commit strobe. The other is a set of parallel pins that are used when direct mode is selected.

Serial bits go into one of two shift targets. An enhancement write-enable picks the target: a 21-bit staging register or an 8-bit auxiliary register. The staging register does not drive the divider. Its contents are copied into a 21-bit active register on the rising edge of the commit strobe, so a partly shifted word never reaches the divider.

All three serial wires are synchronised into the system clock domain, and their edges are detected there. An output stage updates every system clock. It feeds the divider either from the active register or from the parallel pins, depending on the mode input.

Top module: `synth_cfg_reg`

## Requirements
- R1: A serial bit is taken on a rising edge of `ser_clk`, seen after synchronisation. The bit taken is the value `ser_data` held while `ser_clk` was low before that edge. Changes of `ser_data` while `ser_clk` is high, and falling edges of `ser_clk`, shift nothing. Every serial input must hold each level for at least SYNC_STAGES+2 system clocks.
- R2: Bits arrive most significant first. After 21 bits, the first bit is in bit 20 of the staging word. The word layout is: M in bits 20:12 (bit 12 is the LSB), A in bits 11:8, the active-low prescaler control in bit 7, and reserved bits in 6:0.
- R3: While `ser_enh_we` is high, bits shift into the 8-bit auxiliary register, most significant first. Its contents appear on `out_enh`.
- R4: Writes to the auxiliary register leave the staging register unchanged. Staging-register shifts (with `ser_enh_we` low) leave the auxiliary register unchanged.
- R5: While `ser_load` is high, `ser_clk` edges do not change the staging register.
- R6: A rising edge of `ser_load` copies the staging register into the active register. Shifting alone never changes the serial-mode outputs.
- R7: With `direct_sel` high, `out_m`, `out_a` and `out_pre_n` equal `pin_m`, `pin_a` and `pin_pre_n` one clock later.
- R8: With `direct_sel` low, `out_m`, `out_a` and `out_pre_n` equal the M, A and prescaler fields of the active register one clock later.
- R9: A synchronous active-high `rst` clears the staging, auxiliary and active registers and all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Commit strobe; shifting is allowed while it is low |
| ser_enh_we | input | 1 | High: shift into the auxiliary register |
| direct_sel | input | 1 | High: take the settings from the parallel pins |
| pin_m | input | 9 | Parallel M value |
| pin_a | input | 4 | Parallel A value |
| pin_pre_n | input | 1 | Parallel prescaler control, active low |
| out_m | output | 9 | M value to the divider |
| out_a | output | 4 | A value to the divider |
| out_pre_n | output | 1 | Prescaler control to the divider; high means bypass |
| out_enh | output | 8 | Auxiliary register contents |

## Verification
On every cycle, the assertions check four things:
- the staging register freezes while the strobe is high or while the auxiliary register is selected;
- each shift register holds when it is not enabled;
- a commit copies the staging word exactly;
- the output stage follows the source that the mode input selects, one clock later.

Some behaviours can only be shown by the bench's scenarios:
- bit order and field placement;
- the difference between sampling on the rising edge and on the falling edge;
- an ignored frame sent under a high strobe, which becomes visible only after a later commit.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int STG_W   = 21;
  localparam int AUX_W   = 8;
  localparam int M_W     = 9;
  localparam int A_W     = 4;
  localparam int M_LSB   = 12;
  localparam int A_LSB   = 8;
  localparam int PRE_POS = 7;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [A_W-1:0] a;
    logic           pre_n;
  } div_cfg_t;

  function automatic div_cfg_t word_to_cfg(input logic [STG_W-1:0] w);
    div_cfg_t c;
    c.m     = w[M_LSB +: M_W];
    c.a     = w[A_LSB +: A_W];
    c.pre_n = w[PRE_POS];
    return c;
  endfunction
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= stg[STAGES-1];
  end

  assign lvl  = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev;

  p_rise_single_r1: assert property (@(posedge clk) disable iff (rst)
    rise != '0 |=> (rise & $past(rise)) == '0);
endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= {q[W-2:0], din};
  end

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
  p_msb_first_r2: assert property (@(posedge clk) disable iff (rst)
    en |=> q[0] == $past(din) && q[W-1:1] == $past(q[W-2:0]));
endmodule

// File: rtl/cfg_src_mux.sv
module cfg_src_mux
  import synth_cfg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     direct_sel,
  input  div_cfg_t pin_cfg,
  input  div_cfg_t act_cfg,
  output div_cfg_t out_cfg
);
  always_ff @(posedge clk) begin
    if (rst)             out_cfg <= '0;
    else if (direct_sel) out_cfg <= pin_cfg;
    else                 out_cfg <= act_cfg;
  end

  p_direct_src_r7: assert property (@(posedge clk) disable iff (rst)
    direct_sel |=> out_cfg == $past(pin_cfg));
  p_serial_src_r8: assert property (@(posedge clk) disable iff (rst)
    !direct_sel |=> out_cfg == $past(act_cfg));
endmodule

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_load,
  input  logic             ser_enh_we,
  input  logic             direct_sel,
  input  logic [M_W-1:0]   pin_m,
  input  logic [A_W-1:0]   pin_a,
  input  logic             pin_pre_n,
  output logic [M_W-1:0]   out_m,
  output logic [A_W-1:0]   out_a,
  output logic             out_pre_n,
  output logic [AUX_W-1:0] out_enh
);
  localparam int IDX_CLK  = 3;
  localparam int IDX_DAT  = 2;
  localparam int IDX_LOAD = 1;
  localparam int IDX_ENH  = 0;

  logic [3:0] s_lvl, s_rise;
  logic       stg_en, aux_en, commit;
  logic [STG_W-1:0] stg_q, act_q;
  logic [AUX_W-1:0] aux_q;
  div_cfg_t pin_cfg, act_cfg, out_cfg;

  cfg_sync_edge #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({ser_clk, ser_data, ser_load, ser_enh_we}),
    .lvl      (s_lvl),
    .rise     (s_rise)
  );

  assign stg_en = s_rise[IDX_CLK] & ~s_lvl[IDX_ENH] & ~s_lvl[IDX_LOAD];
  assign aux_en = s_rise[IDX_CLK] &  s_lvl[IDX_ENH];
  assign commit = s_rise[IDX_LOAD];

  cfg_shift_chain #(.W(STG_W)) u_stg (
    .clk (clk), .rst (rst), .en (stg_en), .din (s_lvl[IDX_DAT]), .q (stg_q)
  );

  cfg_shift_chain #(.W(AUX_W)) u_aux (
    .clk (clk), .rst (rst), .en (aux_en), .din (s_lvl[IDX_DAT]), .q (aux_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         act_q <= '0;
    else if (commit) act_q <= stg_q;
  end

  assign act_cfg = word_to_cfg(act_q);
  assign pin_cfg = '{m: pin_m, a: pin_a, pre_n: pin_pre_n};

  cfg_src_mux u_mux (
    .clk        (clk),
    .rst        (rst),
    .direct_sel (direct_sel),
    .pin_cfg    (pin_cfg),
    .act_cfg    (act_cfg),
    .out_cfg    (out_cfg)
  );

  assign out_m     = out_cfg.m;
  assign out_a     = out_cfg.a;
  assign out_pre_n = out_cfg.pre_n;
  assign out_enh   = aux_q;

  p_commit_copy_r6: assert property (@(posedge clk) disable iff (rst)
    commit |=> act_q == $past(stg_q));
  p_act_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act_q));
  p_strobe_lock_r5: assert property (@(posedge clk) disable iff (rst)
    s_lvl[IDX_LOAD] |=> $stable(stg_q));
  p_aux_guard_r4: assert property (@(posedge clk) disable iff (rst)
    s_lvl[IDX_ENH] |=> $stable(stg_q));
  p_aux_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !s_lvl[IDX_ENH] |=> $stable(aux_q));
endmodule

// File: tb/synth_cfg_reg_bench.sv
module synth_cfg_reg_bench;
  logic clk = 0, rst = 1;
  logic ser_clk = 0, ser_data = 0, ser_load = 0, ser_enh_we = 0, direct_sel = 0;
  logic [8:0] pin_m = 0;
  logic [3:0] pin_a = 0;
  logic pin_pre_n = 0;
  logic [8:0] out_m;
  logic [3:0] out_a;
  logic out_pre_n;
  logic [7:0] out_enh;
  int total = 0, bad = 0;
  logic [20:0] exp_stg, exp_act;
  logic [7:0]  exp_aux;
  logic [31:0] rnd;

  always #10 clk = ~clk;

  synth_cfg_reg u_synth_cfg_reg (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .ser_enh_we(ser_enh_we), .direct_sel(direct_sel),
    .pin_m(pin_m), .pin_a(pin_a), .pin_pre_n(pin_pre_n),
    .out_m(out_m), .out_a(out_a), .out_pre_n(out_pre_n), .out_enh(out_enh)
  );

  function automatic logic [20:0] mk_word(logic [8:0] m, logic [3:0] a,
                                          logic p, logic [6:0] r);
    return {m, a, p, r};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [20:0] w, int nbits, logic enh);
    ser_enh_we = enh;
    wait_clk(5);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_data = w[i];
      wait_clk(5);
      ser_clk = 1;
      wait_clk(2);
      ser_data = ~w[i];
      wait_clk(3);
      ser_clk = 0;
      wait_clk(1);
    end
    wait_clk(4);
    ser_enh_we = 0;
    wait_clk(5);
  endtask

  task automatic pulse_load();
    ser_load = 1; wait_clk(6);
    ser_load = 0; wait_clk(6);
  endtask

  task automatic chk_serial(string req, logic [20:0] w);
    chk(req, {23'd0, out_m}, {23'd0, w[20:12]});
    chk(req, {28'd0, out_a}, {28'd0, w[11:8]});
    chk(req, {31'd0, out_pre_n}, {31'd0, w[7]});
  endtask

  task automatic chk_pins(string req);
    chk(req, {18'd0, out_m, out_a, out_pre_n}, {18'd0, pin_m, pin_a, pin_pre_n});
  endtask

  initial begin
    wait_clk(200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [20:0] w1, w2, w;
    rnd = $urandom(32'h5eed_1234);
    wait_clk(4);
    rst = 0;
    wait_clk(2);
    // R9 reset state
    chk("R9", {18'd0, out_m, out_a, out_pre_n}, 0);
    chk("R9", {24'd0, out_enh}, 0);

    // R1 R2 R6 R8: directed frame, outputs unchanged until commit
    w1 = mk_word(9'h1A5, 4'hC, 1'b1, 7'h55);
    send(w1, 21, 1'b0);
    chk("R6", {18'd0, out_m, out_a, out_pre_n}, 0);
    pulse_load();
    chk_serial("R2", w1);

    // R3: auxiliary write
    send({13'd0, 8'hA7}, 8, 1'b1);
    chk("R3", {24'd0, out_enh}, 32'hA7);
    // R4: staging untouched by auxiliary write
    pulse_load();
    chk_serial("R4", w1);

    // R5: frame under high strobe is ignored
    ser_load = 1; wait_clk(6);
    w2 = mk_word(9'h0F3, 4'h5, 1'b0, 7'h2A);
    send(w2, 21, 1'b0);
    ser_load = 0; wait_clk(6);
    pulse_load();
    chk_serial("R5", w1);

    // R4: auxiliary holds across a staging load
    send(w2, 21, 1'b0);
    pulse_load();
    chk_serial("R8", w2);
    chk("R4", {24'd0, out_enh}, 32'hA7);

    // R7: direct mode
    direct_sel = 1;
    pin_m = 9'h1FF; pin_a = 4'h0; pin_pre_n = 1;
    wait_clk(2);
    chk_pins("R7");
    pin_m = 9'h001; pin_a = 4'hF; pin_pre_n = 0;
    wait_clk(1);
    chk_pins("R7");
    direct_sel = 0;
    wait_clk(2);
    chk_serial("R8", w2);

    // random mix
    exp_act = w2; exp_aux = 8'hA7;
    for (int k = 0; k < 10; k++) begin
      w = 21'($urandom);
      if ($urandom % 3 == 0) begin
        exp_aux = 8'($urandom);
        send({13'd0, exp_aux}, 8, 1'b1);
        chk("R3", {24'd0, out_enh}, {24'd0, exp_aux});
      end
      send(w, 21, 1'b0);
      pulse_load();
      exp_act = w;
      direct_sel = 1'($urandom);
      pin_m = 9'($urandom); pin_a = 4'($urandom); pin_pre_n = 1'($urandom);
      wait_clk(2);
      if (direct_sel) chk_pins("R7");
      else            chk_serial("R8", exp_act);
      chk("R4", {24'd0, out_enh}, {24'd0, exp_aux});
    end
    direct_sel = 0;

    // R9: reset mid-run
    rst = 1; wait_clk(2); rst = 0; wait_clk(2);
    chk("R9", {18'd0, out_m, out_a, out_pre_n}, 0);
    chk("R9", {24'd0, out_enh}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule